// File: doc/BRIEF.md
# Backplane Register Slave with Grouped I/O and Interrupt Cause Capture

This block is the register file of an instrument card on a 16-bit backplane with A16 addressing. The card holds 32 word registers at even byte offsets 0x00 to 0x3E from its base address. The lower half of that space holds identification, control and interrupt registers. The upper half holds an expansion window and three I/O data registers. Reads are combinational: `rd_data` is valid while `rd_en` is high. Writes take effect on the clock edge where `wr_en` is high. Decoding uses `acc_off[5:1]`; bit 0 is ignored.

The 48 I/O lines form three groups of 16. One configuration bit per group sets the whole group to input or to output. Each group has an output latch that can be written at any time. Offsets 0x20 to 0x38 are not stored inside the block. Accesses there drive a separate expansion port with its own read and write strobes, a 4-bit word address and data lines.

A rising edge on `usr_irq` captures the 3-bit cause and sets a pending flag. Interrupt handling is a two-state machine:

- INT_IDLE to INT_PENDING: on a capture edge.
- INT_PENDING to INT_PENDING: on a capture edge, which overwrites the cause.
- INT_PENDING to INT_IDLE: when the status register is read and no capture edge arrives in the same cycle.

While the machine is in INT_PENDING, the selected active-low backplane interrupt line is driven low, provided the enable bit is set.

Top module: `rsl_regslave`

## Requirements
- R1: After reset:
  - all 48 `gpio_oe` bits are 0;
  - all `gpio_out` bits are 0;
  - `irq_n` is 7'h7F;
  - reads of 0x04, 0x1A and 0x1C return 0x0000.
- R2: Identification registers return parameter values, and writes to them are ignored. The registers are 0x00 (ID), 0x02 (type), 0x08 (attribute), 0x0A (serial high), 0x0C (serial low), 0x0E (version) and 0x1E (subclass). Offset 0x04 is a 16-bit read/write register.
- R3: Reads of the reserved offsets 0x10 to 0x18 return 0xFFFF, and writes to them are ignored. Reads of the write-only offset 0x06 also return 0xFFFF.
- R4: A write to 0x06 loads bits [2:0] as group directions, with 1 meaning output. Bit g drives all 16 bits of `gpio_oe[16g+15:16g]`. Bits [15:3] are ignored.
- R5: A read of 0x3A, 0x3C or 0x3E returns the pin levels `gpio_in[15:0]`, `[31:16]` or `[47:32]` respectively.
- R6: A write to 0x3A, 0x3C or 0x3E updates that group's output latch even while the group is an input. `gpio_out` always shows the latch, so the value appears as soon as the group is switched to output.
- R7: For word offsets 0x20 to 0x38:
  - `exp_addr` is (offset-0x20)/2;
  - `exp_rd_stb` equals `rd_en` and `exp_wr_stb` equals `wr_en`;
  - `rd_data` equals `exp_rdata` and `exp_wdata` equals `wr_data`.
  At any other offset both strobes stay 0.
- R8: A rising edge of `usr_irq` latches `usr_cause` and sets the pending flag at that clock edge.
- R9: A read of 0x1A returns bit 15 = pending and bits [2:0] = last captured cause, with the other bits 0. The read clears the pending flag unless a capture edge occurs in the same cycle.
- R10: The interrupt control register at 0x1C holds bit 15 = enable and bits [2:0] = line select. Both read back, and the other bits read as 0.
- R11: `irq_n[k-1]` is low exactly when the enable bit is set, the select equals k (1 to 7) and a cause is pending. A select of 0 drives no line.
- R12: A capture edge while a cause is already pending overwrites the cause and keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_off | input | 6 | Byte offset from the card base |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data (combinational) |
| gpio_in | input | 48 | I/O pin levels |
| gpio_out | output | 48 | I/O output latches |
| gpio_oe | output | 48 | I/O output enables |
| exp_rd_stb | output | 1 | Expansion read strobe |
| exp_wr_stb | output | 1 | Expansion write strobe |
| exp_addr | output | 4 | Expansion word address |
| exp_wdata | output | 16 | Expansion write data |
| exp_rdata | input | 16 | Expansion read data |
| usr_irq | input | 1 | User interrupt request |
| usr_cause | input | 3 | User cause code |
| irq_n | output | 7 | Active-low backplane interrupt lines 1 to 7 |

## Verification
The assertions check the following on every cycle:
- at most one interrupt line is low, and only while a cause is pending with the enable set;
- each I/O group's enables are uniform;
- a capture edge always leaves the flag set;
- a status read without a capture edge clears the flag;
- expansion strobes appear only for window offsets;
- the control register changes only on its own write.

The bench's scenarios show the rest:
- register values and their read-back layouts;
- which writes are ignored;
- the latched output value surviving a direction switch;
- cause overwrite;
- the read racing a new capture edge.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
    typedef enum logic {INT_IDLE, INT_PENDING} int_state_e;

    localparam int WORDS      = 32;
    localparam int WIDX_W     = 5;
    localparam logic [4:0] W_ID    = 5'd0;
    localparam logic [4:0] W_TYPE  = 5'd1;
    localparam logic [4:0] W_CTL   = 5'd2;
    localparam logic [4:0] W_CFG   = 5'd3;
    localparam logic [4:0] W_ATTR  = 5'd4;
    localparam logic [4:0] W_SERH  = 5'd5;
    localparam logic [4:0] W_SERL  = 5'd6;
    localparam logic [4:0] W_VER   = 5'd7;
    localparam logic [4:0] W_STAT  = 5'd13;
    localparam logic [4:0] W_ICTRL = 5'd14;
    localparam logic [4:0] W_SUBC  = 5'd15;
    localparam logic [4:0] W_EXP0  = 5'd16;
endpackage

// File: rtl/rsl_decode.sv
module rsl_decode
    import rsl_pkg::*;
#(
    parameter int GROUPS = 3,
    parameter int GIW    = 2
) (
    input  logic [WIDX_W-1:0] word,
    output logic              hit_exp,
    output logic              hit_gpio,
    output logic [3:0]        exp_idx,
    output logic [GIW-1:0]    grp_idx
);
    localparam logic [4:0] GPIO_BASE = 5'(WORDS - GROUPS);

    logic [4:0] gdiff;

    always_comb begin
        gdiff    = word - GPIO_BASE;
        hit_gpio = (word >= GPIO_BASE);
        hit_exp  = (word >= W_EXP0) && (word < GPIO_BASE);
        exp_idx  = word[3:0];
        grp_idx  = gdiff[GIW-1:0];
    end
endmodule

// File: rtl/rsl_gpio_bank.sv
module rsl_gpio_bank #(
    parameter int GROUPS = 3,
    parameter int GW     = 16,
    parameter int GIW    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [GROUPS-1:0]    cfg_bits,
    input  logic                 grp_wr,
    input  logic [GIW-1:0]       grp_idx,
    input  logic [GW-1:0]        wdata,
    input  logic [GROUPS*GW-1:0] pins_in,
    output logic [GW-1:0]        grp_rdata,
    output logic [GROUPS*GW-1:0] pins_out,
    output logic [GROUPS*GW-1:0] pins_oe
);
    logic [GROUPS-1:0] dir_q;
    logic [GW-1:0]     in_slice [GROUPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= '0;
        else if (cfg_wr) dir_q <= cfg_bits;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [GW-1:0] lat_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  lat_q <= '0;
            else if (grp_wr && grp_idx == GIW'(g))       lat_q <= wdata;
        end
        assign pins_out[g*GW +: GW] = lat_q;
        assign pins_oe[g*GW +: GW]  = {GW{dir_q[g]}};
        assign in_slice[g]          = pins_in[g*GW +: GW];
    end

    always_comb begin
        grp_rdata = '1;
        for (int g = 0; g < GROUPS; g++)
            if (grp_idx == GIW'(g)) grp_rdata = in_slice[g];
    end
endmodule

// File: rtl/rsl_irq_ctrl.sv
module rsl_irq_ctrl
    import rsl_pkg::*;
#(
    parameter int LINES = 7,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usr_irq,
    input  logic [CW-1:0] usr_cause,
    input  logic          stat_rd,
    input  logic          ctrl_wr,
    input  logic [15:0]   wdata,
    output logic          pend,
    output logic [CW-1:0] cause,
    output logic          int_en,
    output logic [2:0]    int_sel,
    output logic [LINES-1:0] irq_n
);
    int_state_e state_q, state_d;
    logic       irq_prev;
    logic       cap;

    assign cap = usr_irq && !irq_prev;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INT_IDLE:    if (cap) state_d = INT_PENDING;
            INT_PENDING: if (cap)          state_d = INT_PENDING;
                         else if (stat_rd) state_d = INT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= INT_IDLE;
            irq_prev <= 1'b0;
            cause    <= '0;
            int_en   <= 1'b0;
            int_sel  <= '0;
        end else begin
            state_q  <= state_d;
            irq_prev <= usr_irq;
            if (cap) cause <= usr_cause;
            if (ctrl_wr) begin
                int_en  <= wdata[15];
                int_sel <= wdata[2:0];
            end
        end
    end

    always_comb begin
        pend  = (state_q == INT_PENDING);
        irq_n = '1;
        for (int k = 0; k < LINES; k++)
            if (pend && int_en && int_sel == 3'(k + 1)) irq_n[k] = 1'b0;
    end
endmodule

// File: rtl/rsl_regslave.sv
module rsl_regslave
    import rsl_pkg::*;
#(
    parameter int          GROUPS   = 3,
    parameter int          GW       = 16,
    parameter logic [15:0] ID_VAL   = 16'hCEA1,
    parameter logic [15:0] TYPE_VAL = 16'h5A24,
    parameter logic [15:0] ATTR_VAL = 16'hFFFC,
    parameter logic [15:0] SERH_VAL = 16'h0001,
    parameter logic [15:0] SERL_VAL = 16'h2345,
    parameter logic [15:0] VER_VAL  = 16'h0103,
    parameter logic [15:0] SUBC_VAL = 16'hFFFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [5:0]           acc_off,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [15:0]          wr_data,
    output logic [15:0]          rd_data,
    input  logic [GROUPS*GW-1:0] gpio_in,
    output logic [GROUPS*GW-1:0] gpio_out,
    output logic [GROUPS*GW-1:0] gpio_oe,
    output logic                 exp_rd_stb,
    output logic                 exp_wr_stb,
    output logic [3:0]           exp_addr,
    output logic [15:0]          exp_wdata,
    input  logic [15:0]          exp_rdata,
    input  logic                 usr_irq,
    input  logic [2:0]           usr_cause,
    output logic [6:0]           irq_n
);
    localparam int GIW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic [WIDX_W-1:0] word;
    logic              hit_exp, hit_gpio;
    logic [GIW-1:0]    grp_idx;
    logic [GW-1:0]     grp_rdata;
    logic [15:0]       ctl_q;
    logic              irq_pend, int_en;
    logic [2:0]        irq_cause, int_sel;

    assign word = acc_off[5:1];

    rsl_decode #(.GROUPS(GROUPS), .GIW(GIW)) u_dec (
        .word(word), .hit_exp(hit_exp), .hit_gpio(hit_gpio),
        .exp_idx(exp_addr), .grp_idx(grp_idx)
    );

    rsl_gpio_bank #(.GROUPS(GROUPS), .GW(GW), .GIW(GIW)) u_gpio (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(wr_en && word == W_CFG), .cfg_bits(wr_data[GROUPS-1:0]),
        .grp_wr(wr_en && hit_gpio), .grp_idx(grp_idx), .wdata(wr_data[GW-1:0]),
        .pins_in(gpio_in), .grp_rdata(grp_rdata),
        .pins_out(gpio_out), .pins_oe(gpio_oe)
    );

    rsl_irq_ctrl #(.LINES(7), .CW(3)) u_irq (
        .clk(clk), .rst_n(rst_n), .usr_irq(usr_irq), .usr_cause(usr_cause),
        .stat_rd(rd_en && word == W_STAT), .ctrl_wr(wr_en && word == W_ICTRL),
        .wdata(wr_data), .pend(irq_pend), .cause(irq_cause),
        .int_en(int_en), .int_sel(int_sel), .irq_n(irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     ctl_q <= '0;
        else if (wr_en && word == W_CTL) ctl_q <= wr_data;
    end

    assign exp_rd_stb = rd_en && hit_exp;
    assign exp_wr_stb = wr_en && hit_exp;
    assign exp_wdata  = wr_data;

    always_comb begin
        rd_data = 16'hFFFF;
        if (hit_gpio)     rd_data = 16'(grp_rdata);
        else if (hit_exp) rd_data = exp_rdata;
        else begin
            case (word)
                W_ID:    rd_data = ID_VAL;
                W_TYPE:  rd_data = TYPE_VAL;
                W_CTL:   rd_data = ctl_q;
                W_ATTR:  rd_data = ATTR_VAL;
                W_SERH:  rd_data = SERH_VAL;
                W_SERL:  rd_data = SERL_VAL;
                W_VER:   rd_data = VER_VAL;
                W_STAT:  rd_data = {irq_pend, 12'h000, irq_cause};
                W_ICTRL: rd_data = {int_en, 12'h000, int_sel};
                W_SUBC:  rd_data = SUBC_VAL;
                default: rd_data = 16'hFFFF;
            endcase
        end
    end
endmodule

// File: rtl/rsl_regslave_chk.sv
module rsl_regslave_chk #(
    parameter int GROUPS = 3,
    parameter int GW     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [5:0]           acc_off,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic                 usr_irq,
    input logic [6:0]           irq_n,
    input logic [GROUPS*GW-1:0] gpio_oe,
    input logic                 exp_rd_stb,
    input logic                 exp_wr_stb,
    input logic                 pend,
    input logic                 int_en,
    input logic [2:0]           int_sel
);
    logic prev_irq;
    logic in_win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_irq <= 1'b0;
        else        prev_irq <= usr_irq;
    end

    assign in_win = (acc_off[5:1] >= 5'd16) && (acc_off[5:1] <= 5'd28);

    p_irq_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n));

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n != 7'h7F) |-> (pend && int_en));

    for (genvar g = 0; g < GROUPS; g++) begin : g_oe
        p_grp_uniform_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (gpio_oe[g*GW +: GW] == '0) || (gpio_oe[g*GW +: GW] == '1));
    end

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_irq && !prev_irq) |=> pend);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_off[5:1] == 5'd13 && !(usr_irq && !prev_irq)) |=> !pend);

    p_exp_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_wr_stb |-> (wr_en && in_win));

    p_exp_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_rd_stb |-> (rd_en && in_win));

    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && acc_off[5:1] == 5'd14) |=> ($stable(int_en) && $stable(int_sel)));
endmodule

bind rsl_regslave rsl_regslave_chk #(.GROUPS(GROUPS), .GW(GW)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_off(acc_off), .rd_en(rd_en), .wr_en(wr_en),
    .usr_irq(usr_irq), .irq_n(irq_n), .gpio_oe(gpio_oe),
    .exp_rd_stb(exp_rd_stb), .exp_wr_stb(exp_wr_stb),
    .pend(irq_pend), .int_en(int_en), .int_sel(int_sel)
);

// File: tb/rsl_regslave_tb.sv
`timescale 1ns/1ps
module rsl_regslave_tb;
    logic        clk = 0, rst_n = 0;
    logic [5:0]  acc_off = 0;
    logic        rd_en = 0, wr_en = 0;
    logic [15:0] wr_data = 0, rd_data;
    logic [47:0] gpio_in = 0, gpio_out, gpio_oe;
    logic        exp_rd_stb, exp_wr_stb;
    logic [3:0]  exp_addr;
    logic [15:0] exp_wdata, exp_rdata = 0;
    logic        usr_irq = 0;
    logic [2:0]  usr_cause = 0;
    logic [6:0]  irq_n;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    rsl_regslave u_dut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] off, logic [15:0] d);
        @(negedge clk); acc_off = off; wr_data = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [5:0] off, output logic [15:0] d);
        @(negedge clk); acc_off = off; rd_en = 1;
        #2 d = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic pulse(logic [2:0] c);
        @(negedge clk); usr_irq = 1; usr_cause = c;
        @(negedge clk); usr_irq = 0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R1 oe", gpio_oe, 0);
        chk("R1 out", gpio_out, 0);
        chk("R1 irq_n", irq_n, 7'h7F);
        rd(6'h04, d); chk("R1 ctl", d, 0);
        rd(6'h1A, d); chk("R1 stat", d, 0);
        rd(6'h1C, d); chk("R1 ictrl", d, 0);
    endtask

    task automatic t_ids;
        logic [15:0] d;
        rd(6'h00, d); chk("R2 id", d, 16'hCEA1);
        rd(6'h02, d); chk("R2 type", d, 16'h5A24);
        rd(6'h08, d); chk("R2 attr", d, 16'hFFFC);
        rd(6'h0A, d); chk("R2 serh", d, 16'h0001);
        rd(6'h0C, d); chk("R2 serl", d, 16'h2345);
        rd(6'h0E, d); chk("R2 ver", d, 16'h0103);
        rd(6'h1E, d); chk("R2 subc", d, 16'hFFFE);
        wr(6'h00, 16'h0000); rd(6'h00, d); chk("R2 id write ignored", d, 16'hCEA1);
        wr(6'h04, 16'hB00C); rd(6'h04, d); chk("R2 ctl rw", d, 16'hB00C);
    endtask

    task automatic t_reserved;
        logic [15:0] d;
        rd(6'h10, d); chk("R3 0x10", d, 16'hFFFF);
        rd(6'h12, d); chk("R3 0x12", d, 16'hFFFF);
        rd(6'h18, d); chk("R3 0x18", d, 16'hFFFF);
        wr(6'h14, 16'h0000); rd(6'h14, d); chk("R3 0x14 write ignored", d, 16'hFFFF);
        rd(6'h06, d); chk("R3 cfg write-only", d, 16'hFFFF);
    endtask

    task automatic t_cfg;
        wr(6'h06, 16'hFF05);
        chk("R4 groups 0,2 out", gpio_oe, 48'hFFFF_0000_FFFF);
        wr(6'h06, 16'h0002);
        chk("R4 group 1 out", gpio_oe, 48'h0000_FFFF_0000);
        wr(6'h06, 16'h0000);
        chk("R4 all in", gpio_oe, 0);
    endtask

    task automatic t_pins;
        logic [15:0] d;
        gpio_in = 48'hA5A5_1234_BEEF;
        rd(6'h3A, d); chk("R5 grp0", d, 16'hBEEF);
        rd(6'h3C, d); chk("R5 grp1", d, 16'h1234);
        rd(6'h3E, d); chk("R5 grp2", d, 16'hA5A5);
    endtask

    task automatic t_latch;
        wr(6'h3C, 16'h5678);
        chk("R6 latch while input", gpio_out[31:16], 16'h5678);
        chk("R6 still input", gpio_oe[31:16], 0);
        wr(6'h06, 16'h0002);
        chk("R6 now output", gpio_oe[31:16], 16'hFFFF);
        chk("R6 value kept", gpio_out, 48'h0000_5678_0000);
        wr(6'h06, 16'h0000);
    endtask

    task automatic t_exp;
        @(negedge clk); acc_off = 6'h24; exp_rdata = 16'h7E81; rd_en = 1;
        #2;
        chk("R7 rd stb", exp_rd_stb, 1);
        chk("R7 rd addr", exp_addr, 2);
        chk("R7 rd data", rd_data, 16'h7E81);
        chk("R7 no wr stb", exp_wr_stb, 0);
        @(negedge clk); rd_en = 0;
        acc_off = 6'h38; wr_data = 16'h1357; wr_en = 1;
        #2;
        chk("R7 wr stb", exp_wr_stb, 1);
        chk("R7 wr addr", exp_addr, 12);
        chk("R7 wr data", exp_wdata, 16'h1357);
        @(negedge clk); wr_en = 0;
        acc_off = 6'h3A; rd_en = 1;
        #2 chk("R7 outside window", exp_rd_stb, 0);
        @(negedge clk); rd_en = 0;
    endtask

    task automatic t_irq;
        logic [15:0] d;
        pulse(3'd3);
        rd(6'h1A, d); chk("R8 capture", d, 16'h8003);
        rd(6'h1A, d); chk("R9 cleared by read", d, 16'h0003);
        pulse(3'd2); pulse(3'd6);
        rd(6'h1A, d); chk("R12 overwrite", d, 16'h8006);
        pulse(3'd1);
        @(negedge clk); acc_off = 6'h1A; rd_en = 1; usr_irq = 1; usr_cause = 3'd5;
        #2 d = rd_data;
        @(negedge clk); rd_en = 0; usr_irq = 0;
        chk("R9 read before race", d, 16'h8001);
        rd(6'h1A, d); chk("R9 race keeps pending", d, 16'h8005);
    endtask

    task automatic t_lines;
        logic [15:0] d;
        wr(6'h1C, 16'hFFFB);
        rd(6'h1C, d); chk("R10 readback", d, 16'h8003);
        chk("R11 none pending", irq_n, 7'h7F);
        pulse(3'd4);
        #1 chk("R11 line 3", irq_n, 7'b1111011);
        wr(6'h1C, 16'h0003);
        chk("R11 disabled", irq_n, 7'h7F);
        wr(6'h1C, 16'h8000);
        chk("R11 select 0", irq_n, 7'h7F);
        wr(6'h1C, 16'h8007);
        chk("R11 line 7", irq_n, 7'b0111111);
        rd(6'h1A, d);
        chk("R11 released after read", irq_n, 7'h7F);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ids();
        t_reserved();
        t_cfg();
        t_pins();
        t_latch();
        t_exp();
        t_irq();
        t_lines();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule